// File: doc/BRIEF.md
# Real-Time Clock Alarm and Interrupt Flag Unit

This block keeps the alarm settings and the interrupt status of a PC-style real-time clock. A separate time-keeping block supplies the current seconds, minutes, hours, day of month and month as bytes. It also supplies a one-cycle strobe when each one-second update ends, and a one-cycle periodic tick. On every update strobe the unit compares the current time with the alarm bytes. It latches three event flags (periodic, alarm, update-ended). It drives a level interrupt whenever a latched event is also enabled.

Software uses a byte-wide register port. Addresses 0 to 4 hold the alarm bytes for seconds, minutes, hours, day of month and month. Address 5 holds the control byte and address 6 holds the flag byte, which is read-only. Address 7 reads as zero. The control byte holds the three interrupt enables and the binary/BCD selector. It also carries a 24-hour indicator that is always set, because hours are taken in 24-hour form only. A flag-byte read returns the latched flags and clears them in the same cycle. The day and month alarms can be left out through parameters.

Top module: `rtc_alarm_irq_unit`

## Requirements
- R1: After synchronous reset, the control byte reads 0x02 (all enables clear, BCD, 24-hour), the flag byte reads 0x00, every alarm byte reads 0x00, and `irq_out` is low.
- R2: Writes to addresses 0..4 store the alarm byte and it reads back unchanged. A control write keeps only bits 6, 5, 4 (periodic, alarm and update enables) and bit 2 (binary mode); bit 1 always reads 1 and bits 7, 3 and 0 always read 0. The control byte changes only through a write to address 5.
- R3: A cycle with `upd_strobe` high sets the update flag (flag bit 4) at that clock edge. A cycle with `per_tick` high sets the periodic flag (flag bit 6).
- R4: In a cycle with `upd_strobe` high, the alarm flag (flag bit 5) sets at that edge when every alarm field matches the current time. The bytes are compared as raw values, so the match works the same in BCD mode and in binary mode (control bit 2).
- R5: A seconds, minutes, hours or month alarm byte whose bits 7 and 6 are both set (0xC0..0xFF, 0xFF included) matches any value of that field.
- R6: The day alarm compares only bits 5..0 with the day of month, and a zero in those bits means no day constraint. A month alarm of 0x00 means no month constraint. The month alarm takes part only when the day alarm is built in.
- R7: Flags latch whether or not their enables are set, and they stay set until the flag byte is read. Flag bit 7 (summary) reads 1 exactly when some latched flag has its enable set, including when the enable is set after the flag.
- R8: `irq_out` is an active-high level that equals the summary bit.
- R9: A flag-byte read returns the flags held before the read, summary included, on `reg_rdata` after that edge. It clears all flags at the same edge, so `irq_out` is low in the cycle after the read. An event arriving in the read cycle is still set afterwards.
- R10: Writes to the flag byte address have no effect on the flags.
- R11: The alarm flag never sets in a cycle without `upd_strobe`, however well the time matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (flag read clears flags) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered, holds until next read |
| now_sec | input | 8 | Current seconds |
| now_min | input | 8 | Current minutes |
| now_hour | input | 8 | Current hours, 24-hour form |
| now_mday | input | 8 | Current day of month |
| now_mon | input | 8 | Current month |
| upd_strobe | input | 1 | One-cycle pulse at the end of each one-second update |
| per_tick | input | 1 | One-cycle periodic event |
| irq_out | output | 1 | Level interrupt, active high |

## Verification
Some properties are checked by assertions on every cycle. Flags never drop without a flag read. The update and periodic events always leave their flag set. A flag read with no new event empties the flags. The alarm flag never rises without the update strobe. Writes to the flag address leave the flags alone. The control byte moves only on its own write. The interrupt stays up until a read or a control write. Other behaviour only the bench scenarios can show: the wildcard and zero-constraint alarm codes, the 6-bit day comparison, matching in binary mode, and an enable set after its flag. They also show the exact bytes returned by a flag read that coincides with a new event.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_SEC  = 3'd0,
        A_MIN  = 3'd1,
        A_HOUR = 3'd2,
        A_DAY  = 3'd3,
        A_MON  = 3'd4,
        A_CTRL = 3'd5,
        A_FLAG = 3'd6
    } reg_sel_e;

    // bit positions shared by control enables and flags
    localparam int BIT_SUM = 7;
    localparam int BIT_PER = 6;
    localparam int BIT_ALM = 5;
    localparam int BIT_UPD = 4;
    localparam int BIT_BIN = 2;
    localparam int BIT_H24 = 1;
    localparam int EVT_LO  = BIT_UPD;
    localparam int EVT_HI  = BIT_PER;

    localparam logic [DATA_W-1:0] CTRL_WMASK = 8'h74;
    localparam logic [DATA_W-1:0] CTRL_RESET = 8'h02;

    typedef struct packed {
        logic [DATA_W-1:0] sec;
        logic [DATA_W-1:0] min;
        logic [DATA_W-1:0] hour;
        logic [DATA_W-1:0] day;
        logic [DATA_W-1:0] mon;
    } alarm_set_t;

    typedef struct packed {
        logic [DATA_W-1:0] sec;
        logic [DATA_W-1:0] min;
        logic [DATA_W-1:0] hour;
        logic [DATA_W-1:0] mday;
        logic [DATA_W-1:0] mon;
    } time_now_t;

    // packed order follows flag bits 6..4
    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } evt_t;

    function automatic logic is_wild(input logic [DATA_W-1:0] v);
        return v[DATA_W-1] & v[DATA_W-2];
    endfunction

    function automatic logic field_hit(input logic [DATA_W-1:0] a,
                                       input logic [DATA_W-1:0] t);
        return is_wild(a) || (a == t);
    endfunction

endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter bit HAS_DAY = 1'b1,
    parameter bit HAS_MON = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output alarm_set_t        alarm_q,
    output logic [DATA_W-1:0] ctrl_q
);

    logic [DATA_W-1:0] sec_q, min_q, hour_q, day_q, mon_q;
    logic ctrl_wr;

    assign ctrl_wr = wr_en && (addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q  <= '0;
            min_q  <= '0;
            hour_q <= '0;
            ctrl_q <= CTRL_RESET;
        end else if (wr_en) begin
            case (addr)
                A_SEC:   sec_q  <= wdata;
                A_MIN:   min_q  <= wdata;
                A_HOUR:  hour_q <= wdata;
                A_CTRL:  ctrl_q <= (wdata & CTRL_WMASK) | CTRL_RESET;
                default: ;
            endcase
        end
    end

    generate
        if (HAS_DAY) begin : g_day
            always_ff @(posedge clk) begin
                if (rst)
                    day_q <= '0;
                else if (wr_en && (addr == A_DAY))
                    day_q <= wdata;
            end
        end else begin : g_no_day
            assign day_q = '0;
        end

        if (HAS_DAY && HAS_MON) begin : g_mon
            always_ff @(posedge clk) begin
                if (rst)
                    mon_q <= '0;
                else if (wr_en && (addr == A_MON))
                    mon_q <= wdata;
            end
        end else begin : g_no_mon
            assign mon_q = '0;
        end
    endgenerate

    assign alarm_q = '{sec: sec_q, min: min_q, hour: hour_q, day: day_q, mon: mon_q};

    // R2: control byte only moves on a write to its own address
    assert_ctrl_write_only_R2: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(ctrl_q));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter bit HAS_DAY = 1'b1,
    parameter bit HAS_MON = 1'b1
) (
    input  alarm_set_t alarm_i,
    input  time_now_t  now_i,
    output logic       hit_o
);

    localparam logic [DATA_W-1:0] DAY_MASK = 8'h3F;

    logic hms_ok, day_ok, mon_ok;

    assign hms_ok = field_hit(alarm_i.sec,  now_i.sec)
                  & field_hit(alarm_i.min,  now_i.min)
                  & field_hit(alarm_i.hour, now_i.hour);

    generate
        if (HAS_DAY) begin : g_day_cmp
            logic [DATA_W-1:0] a_day, t_day;
            assign a_day  = alarm_i.day & DAY_MASK;
            assign t_day  = now_i.mday & DAY_MASK;
            assign day_ok = (a_day == '0) || (a_day == t_day);
        end else begin : g_day_none
            assign day_ok = 1'b1;
        end

        if (HAS_DAY && HAS_MON) begin : g_mon_cmp
            assign mon_ok = (alarm_i.mon == '0) || field_hit(alarm_i.mon, now_i.mon);
        end else begin : g_mon_none
            assign mon_ok = 1'b1;
        end
    endgenerate

    assign hit_o = hms_ok & day_ok & mon_ok;

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t set_i,
    input  logic clr_i,
    input  evt_t en_i,
    output evt_t flags_q,
    output logic summary_o
);

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else if (clr_i)
            flags_q <= set_i;
        else
            flags_q <= flags_q | set_i;
    end

    assign summary_o = |(flags_q & en_i);

    // R7: a latched flag never drops without a flag read
    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((flags_q | $past(flags_q)) == flags_q));

    // R9: a read with no new event leaves no flag
    assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_i && (set_i == '0)) |=> (flags_q == '0));

    // R3: update strobe always leaves the update flag set
    assert_upd_sets_R3: assert property (@(posedge clk) disable iff (rst)
        set_i.upd |=> flags_q.upd);

    // R3: periodic tick always leaves the periodic flag set
    assert_per_sets_R3: assert property (@(posedge clk) disable iff (rst)
        set_i.per |=> flags_q.per);

endmodule

// File: rtl/rtc_alarm_irq_unit.sv
module rtc_alarm_irq_unit
    import rtc_alarm_pkg::*;
#(
    parameter bit HAS_DAY = 1'b1,
    parameter bit HAS_MON = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] now_sec,
    input  logic [DATA_W-1:0] now_min,
    input  logic [DATA_W-1:0] now_hour,
    input  logic [DATA_W-1:0] now_mday,
    input  logic [DATA_W-1:0] now_mon,
    input  logic              upd_strobe,
    input  logic              per_tick,
    output logic              irq_out
);

    alarm_set_t        alarm_q;
    logic [DATA_W-1:0] ctrl_q;
    time_now_t         now;
    logic              hit;
    evt_t              evt_set, evt_en, flags_q;
    logic              flag_clr, summary;
    logic [DATA_W-1:0] flag_byte, rd_mux;

    assign now = '{sec: now_sec, min: now_min, hour: now_hour, mday: now_mday, mon: now_mon};

    rtc_alarm_regs #(.HAS_DAY(HAS_DAY), .HAS_MON(HAS_MON)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .alarm_q (alarm_q),
        .ctrl_q  (ctrl_q)
    );

    rtc_alarm_match #(.HAS_DAY(HAS_DAY), .HAS_MON(HAS_MON)) u_match (
        .alarm_i (alarm_q),
        .now_i   (now),
        .hit_o   (hit)
    );

    assign evt_set  = '{per: per_tick, alm: upd_strobe & hit, upd: upd_strobe};
    assign evt_en   = evt_t'(ctrl_q[EVT_HI:EVT_LO]);
    assign flag_clr = reg_rd && (reg_addr == A_FLAG);

    rtc_irq_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .set_i     (evt_set),
        .clr_i     (flag_clr),
        .en_i      (evt_en),
        .flags_q   (flags_q),
        .summary_o (summary)
    );

    assign flag_byte = {summary, flags_q, 4'b0000};

    always_comb begin
        case (reg_addr)
            A_SEC:   rd_mux = alarm_q.sec;
            A_MIN:   rd_mux = alarm_q.min;
            A_HOUR:  rd_mux = alarm_q.hour;
            A_DAY:   rd_mux = alarm_q.day;
            A_MON:   rd_mux = alarm_q.mon;
            A_CTRL:  rd_mux = ctrl_q;
            A_FLAG:  rd_mux = flag_byte;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_mux;
    end

    assign irq_out = summary;

    // R11: no alarm flag rise without the update strobe
    assert_alarm_on_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        !upd_strobe |=> !$rose(flags_q.alm));

    // R10: a write to the flag address with no event leaves flags alone
    assert_flag_wr_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_addr == A_FLAG) && !flag_clr && !upd_strobe && !per_tick)
        |=> $stable(flags_q));

    // R8: the interrupt level holds until a flag read or a control write
    assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_out && !flag_clr && !(reg_wr && (reg_addr == A_CTRL))) |=> irq_out);

endmodule

// File: tb/rtc_alarm_irq_unit_bench.sv
module rtc_alarm_irq_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] t_sec = '0, t_min = '0, t_hour = '0, t_mday = '0, t_mon = '0;
    logic       upd = 1'b0, per = 1'b0;
    logic       irq_out;

    int vectors = 0;
    int errors  = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    rtc_alarm_irq_unit u_rtc_alarm_irq_unit (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .now_sec(t_sec), .now_min(t_min), .now_hour(t_hour), .now_mday(t_mday), .now_mon(t_mon),
        .upd_strobe(upd), .per_tick(per), .irq_out(irq_out)
    );

    // ---------------- behavioural reference model ----------------
    byte unsigned m_alarm[5];
    byte unsigned m_ctrl, m_rdata;
    bit m_per, m_alm, m_upd;

    function automatic bit m_sum();
        return (m_per & m_ctrl[6]) | (m_alm & m_ctrl[5]) | (m_upd & m_ctrl[4]);
    endfunction

    function automatic bit m_field(byte unsigned a, byte unsigned t);
        return (a >= 8'hC0) || (a == t);
    endfunction

    function automatic bit m_match();
        bit day_ok, mon_ok;
        day_ok = ((m_alarm[3] % 64) == 0) || ((m_alarm[3] % 64) == (t_mday % 64));
        mon_ok = (m_alarm[4] == 0) || m_field(m_alarm[4], t_mon);
        return m_field(m_alarm[0], t_sec) && m_field(m_alarm[1], t_min) &&
               m_field(m_alarm[2], t_hour) && day_ok && mon_ok;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_alarm[i]) m_alarm[i] = 0;
            m_ctrl = 8'h02; m_rdata = 0;
            m_per = 0; m_alm = 0; m_upd = 0;
        end else begin
            bit hit;
            hit = m_match();
            if (reg_rd) begin
                if (reg_addr < 5) m_rdata = m_alarm[reg_addr];
                else if (reg_addr == 5) m_rdata = m_ctrl;
                else if (reg_addr == 6) m_rdata = {m_sum(), m_per, m_alm, m_upd, 4'b0};
                else m_rdata = 0;
            end
            if (reg_rd && reg_addr == 6) begin
                m_per = 0; m_alm = 0; m_upd = 0;
            end
            if (per) m_per = 1;
            if (upd) m_upd = 1;
            if (upd && hit) m_alm = 1;
            if (reg_wr) begin
                if (reg_addr < 5) m_alarm[reg_addr] = reg_wdata;
                else if (reg_addr == 5) m_ctrl = (reg_wdata & 8'h74) | 8'h02;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            vectors++;
            if (irq_out !== m_sum() || reg_rdata !== m_rdata) begin
                errors++;
                $display("FAIL %s model: irq=%0b exp %0b rdata=%02h exp %02h",
                         cur_req, irq_out, m_sum(), reg_rdata, m_rdata);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input bit wr, input bit rd, input logic [2:0] a,
                        input logic [7:0] d, input bit u, input bit p);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; upd = u; per = p;
    endtask

    task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string req);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic expect_read(input logic [2:0] a, input logic [7:0] exp, input string req);
        step(0, 1, a, 0, 0, 0);
        idle();
        check8(reg_rdata, exp, req);
    endtask

    task automatic expect_irq(input bit exp, input string req);
        check8({7'b0, irq_out}, {7'b0, exp}, req);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d); step(1, 0, a, d, 0, 0); endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                            input logic [7:0] dd, input logic [7:0] mo);
        t_sec = s; t_min = mi; t_hour = h; t_mday = dd; t_mon = mo;
    endtask

    task automatic set_alarm(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                             input logic [7:0] dd, input logic [7:0] mo);
        wr(0, s); wr(1, mi); wr(2, h); wr(3, dd); wr(4, mo);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        cur_req = "R1";
        expect_irq(0, "R1 irq after reset");
        expect_read(5, 8'h02, "R1 control reset");
        expect_read(6, 8'h00, "R1 flags reset");
        expect_read(0, 8'h00, "R1 alarm sec reset");

        cur_req = "R2";
        set_alarm(8'h30, 8'h15, 8'h23, 8'h12, 8'h06);
        expect_read(0, 8'h30, "R2 alarm sec");
        expect_read(2, 8'h23, "R2 alarm hour");
        expect_read(4, 8'h06, "R2 alarm month");
        wr(5, 8'hFF);
        expect_read(5, 8'h76, "R2 control write mask");
        wr(5, 8'h00);
        expect_read(5, 8'h02, "R2 control 24h bit kept");
        expect_read(7, 8'h00, "R2 unused address");

        cur_req = "R3";
        set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
        step(0, 0, 0, 0, 0, 1);
        expect_read(6, 8'h40, "R3 periodic flag");
        step(0, 0, 0, 0, 1, 0);
        expect_read(6, 8'h10, "R3 update flag, no alarm");
        expect_read(6, 8'h00, "R9 flags cleared by read");

        cur_req = "R4";
        set_time(8'h30, 8'h15, 8'h23, 8'h12, 8'h06);
        cur_req = "R11";
        idle(); idle(); idle();
        expect_read(6, 8'h00, "R11 no strobe no alarm");
        cur_req = "R4";
        step(0, 0, 0, 0, 1, 0);
        expect_read(6, 8'h30, "R4 BCD alarm match");
        wr(5, 8'h04);
        expect_read(5, 8'h06, "R4 binary mode control");
        set_alarm(8'h2D, 8'h3B, 8'h17, 8'h00, 8'h00);
        set_time(8'h2D, 8'h3B, 8'h17, 8'h1F, 8'h0C);
        step(0, 0, 0, 0, 1, 0);
        expect_read(6, 8'h30, "R4 binary alarm match");
        set_time(8'h2C, 8'h3B, 8'h17, 8'h1F, 8'h0C);
        step(0, 0, 0, 0, 1, 0);
        expect_read(6, 8'h10, "R4 binary mismatch");
        wr(5, 8'h00);

        cur_req = "R5";
        set_alarm(8'hFF, 8'hC5, 8'h23, 8'h00, 8'hFF);
        set_time(8'h07, 8'h44, 8'h23, 8'h05, 8'h11);
        step(0, 0, 0, 0, 1, 0);
        expect_read(6, 8'h30, "R5 wildcard sec/min/mon");
        set_time(8'h07, 8'h44, 8'h22, 8'h05, 8'h11);
        step(0, 0, 0, 0, 1, 0);
        expect_read(6, 8'h10, "R5 hour not wild");

        cur_req = "R6";
        set_alarm(8'h10, 8'h20, 8'h05, 8'hD2, 8'h00);
        set_time(8'h10, 8'h20, 8'h05, 8'h12, 8'h09);
        step(0, 0, 0, 0, 1, 0);
        expect_read(6, 8'h30, "R6 day low 6 bits match");
        set_time(8'h10, 8'h20, 8'h05, 8'h13, 8'h09);
        step(0, 0, 0, 0, 1, 0);
        expect_read(6, 8'h10, "R6 day mismatch");
        wr(3, 8'h00);
        step(0, 0, 0, 0, 1, 0);
        expect_read(6, 8'h30, "R6 day zero any");
        wr(3, 8'h13); wr(4, 8'h09);
        step(0, 0, 0, 0, 1, 0);
        expect_read(6, 8'h30, "R6 month match");
        t_mon = 8'h10;
        step(0, 0, 0, 0, 1, 0);
        expect_read(6, 8'h10, "R6 month mismatch");

        cur_req = "R7";
        wr(5, 8'h20);
        t_mon = 8'h09;
        step(0, 0, 0, 0, 0, 1);
        idle();
        expect_irq(0, "R7 periodic flag without enable");
        step(0, 0, 0, 0, 1, 0);
        idle();
        cur_req = "R8";
        expect_irq(1, "R8 irq on enabled alarm");
        idle();
        expect_irq(1, "R8 irq level holds");
        cur_req = "R9";
        step(0, 1, 6, 0, 0, 0);
        idle();
        check8(reg_rdata, 8'hF0, "R9 read flags with summary");
        expect_irq(0, "R9 irq low after read");
        cur_req = "R7";
        wr(5, 8'h00);
        step(0, 0, 0, 0, 0, 1);
        idle();
        expect_irq(0, "R7 flag set enable clear");
        wr(5, 8'h40);
        idle();
        expect_irq(1, "R7 late enable raises irq");
        expect_read(6, 8'hC0, "R7 summary from late enable");
        wr(5, 8'h00);

        cur_req = "R9";
        step(0, 1, 6, 0, 0, 1);
        idle();
        check8(reg_rdata, 8'h00, "R9 read in event cycle old value");
        expect_read(6, 8'h40, "R9 event in read cycle kept");

        cur_req = "R10";
        step(0, 0, 0, 0, 0, 1);
        wr(6, 8'h00);
        wr(6, 8'hFF);
        expect_read(6, 8'h40, "R10 flag write ignored");

        idle(); idle();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule